// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers interrupt requests from a USB controller and its endpoints and turns them into interrupt outputs. It keeps three status registers. The first is an 8-bit core register. Each of its bits drives a line of its own. The second and third are 16-bit endpoint registers, one for transmit and one for receive. Each endpoint register drives a single shared output. Every bit of all three registers is qualified by an enable bit of its own.

Endpoint logic sends two kinds of request, set and clear. Each names a direction and one line, on separate channels, so a set and a clear can arrive in the same cycle. Endpoint 0 is handled as a control pipe. A receive request on line 0 therefore lands in transmit bit 0. Software sees both endpoint registers through one packed 32-bit word. It can acknowledge many bits in one cycle with a 32-bit keep mask, using the same bit layout as the packed word. A small synchronous write port loads the three enable registers.

An asynchronous active-low reset clears the block at once. Its release is synchronised, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `usb_irq_aggregator`

## Requirements
- R1: While in reset, and after it, every status bit is 0 and `tx_irq`, `rx_irq`, `core_irq` and `status_packed` are 0. After reset the transmit and receive enables are all ones and the core enable is 8'h06, so only core lines 1 and 2 can be set.
- R2: Assume the set request is not also cleared in that cycle. An endpoint set request whose enable bit is 1 sets that status bit and raises the shared output of its direction at the next clock edge. If the enable bit is 0, the request is lost. A later change to the enable does not bring it back. Direction encoding: 0 = transmit, 1 = receive.
- R3: An endpoint clear request resets that status bit at the next edge. The shared output of that direction falls only once every bit of its register is 0. While any bit is still set, the output stays high.
- R4: An endpoint request for receive line 0 acts on transmit bit 0 instead, for both set and clear, and uses the transmit enable bit 0. Receive status bit 0 is never set.
- R5: `status_packed` equals the receive status shifted left by 15, ORed with the transmit status. It follows the registers in the same cycle.
- R6: When `bulk_clr_vld` is 1, the receive status is ANDed with bits 30:15 of `bulk_clr_mask`, and the transmit status is ANDed with bits 15:0. Bit 31 is ignored. Each shared output falls in that same edge if its register becomes 0.
- R7: The core register has 8 bits. In order from bit 0 they are: suspend, resume, reset/babble, start of frame, connect, disconnect, session request and VBUS error. `core_set[i]` sets bit i only when core enable bit i is 1. `core_clr[i]` clears bit i. `core_irq[i]` is bit i.
- R8: A clear for a bit wins over a set for the same bit in the same cycle. This holds for endpoint clear, core clear and bulk clear alike.
- R9: A write loads an enable register. Address 0 loads the transmit enable and address 1 loads the receive enable, each from `reg_wdata[15:0]`. Address 2 loads the core enable from `reg_wdata[7:0]`. Address 3 changes nothing. A new enable takes effect from the next edge, so a set in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_set_vld | input | 1 | Endpoint set request valid |
| ep_set_dir | input | 1 | Set direction, 0 transmit, 1 receive |
| ep_set_idx | input | 4 | Set endpoint line |
| ep_clr_vld | input | 1 | Endpoint clear request valid |
| ep_clr_dir | input | 1 | Clear direction, 0 transmit, 1 receive |
| ep_clr_idx | input | 4 | Clear endpoint line |
| core_set | input | 8 | Core event set pulses, one per line |
| core_clr | input | 8 | Core event clear pulses, one per line |
| bulk_clr_vld | input | 1 | Apply bulk keep mask |
| bulk_clr_mask | input | 32 | Bulk keep mask, packed layout |
| reg_we | input | 1 | Enable register write strobe |
| reg_addr | input | 2 | Enable register select |
| reg_wdata | input | 16 | Enable register write data |
| status_packed | output | 32 | Packed endpoint status |
| tx_irq | output | 1 | Shared transmit interrupt |
| rx_irq | output | 1 | Shared receive interrupt |
| core_irq | output | 8 | Core interrupt lines |

## Verification
On every cycle, the assertions check four things. Each shared output agrees with whether its register holds any bit. A clear or a bulk mask always removes the bits it targets. A request arriving at a disabled bit never shows up in the status. Receive bit 0 stays at zero, and an enable register holds its value unless it is written through a valid address. Some properties can only be shown by the bench's scenarios. These include the exact packed layout with its overlap at bit 15, the redirection of a line-0 receive request into the transmit word, the old enable applying in the cycle of a write, a dropped request not coming back later, and the reset values seen through the ports.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
package usb_irq_pkg;
  typedef enum logic [1:0] {
    SEL_TX_EN   = 2'd0,
    SEL_RX_EN   = 2'd1,
    SEL_CORE_EN = 2'd2,
    SEL_NONE    = 2'd3
  } en_sel_e;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } ep_dir_e;
endpackage

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] keep_vec,
  input  logic [W-1:0] en_vec,
  output logic [W-1:0] status,
  output logic         any_irq
);
  logic [W-1:0] status_d;
  logic         any_d;
  logic         upd;

  always_comb begin
    status_d = (status | (set_vec & en_vec)) & ~clr_vec & keep_vec;
    any_d    = |status_d;
    upd      = (|set_vec) | (|clr_vec) | ~(&keep_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      any_irq <= 1'b0;
    end else if (upd) begin
      status  <= status_d;
      any_irq <= any_d;
    end
  end

  // R3: shared output high exactly while some bit is held
  a_r3_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    any_irq == (status != '0));
  // R2: a request arriving at a disabled, clear bit leaves no trace
  a_r2_drop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec & ~en_vec & ~status)) == '0));
  // R8: clear wins over set
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_vec)) == '0));
  // R2: enabled, uncleared set is recorded
  a_r2_set_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(set_vec & en_vec & ~clr_vec & keep_vec)) == '0));
endmodule

// File: rtl/ep_req_router.sv
`timescale 1ns/1ps
module ep_req_router
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int IDX_W  = $clog2(NUM_EP)
) (
  input  logic              set_vld,
  input  logic              set_dir,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              clr_vld,
  input  logic              clr_dir,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [NUM_EP-1:0] tx_set,
  output logic [NUM_EP-1:0] rx_set,
  output logic [NUM_EP-1:0] tx_clr,
  output logic [NUM_EP-1:0] rx_clr
);
  logic set_to_rx;
  logic clr_to_rx;

  always_comb begin
    set_to_rx = (set_dir == DIR_RX) && (set_idx != '0);
    clr_to_rx = (clr_dir == DIR_RX) && (clr_idx != '0);
    tx_set = '0;
    rx_set = '0;
    tx_clr = '0;
    rx_clr = '0;
    if (set_vld) begin
      if (set_to_rx) rx_set[set_idx] = 1'b1;
      else           tx_set[set_idx] = 1'b1;
    end
    if (clr_vld) begin
      if (clr_to_rx) rx_clr[clr_idx] = 1'b1;
      else           tx_clr[clr_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
`timescale 1ns/1ps
module irq_enable_regs
  import usb_irq_pkg::*;
#(
  parameter int               NUM_EP      = 16,
  parameter int               CORE_W      = 8,
  parameter logic [CORE_W-1:0] CORE_EN_RST = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [NUM_EP-1:0] wdata,
  output logic [NUM_EP-1:0] tx_en,
  output logic [NUM_EP-1:0] rx_en,
  output logic [CORE_W-1:0] core_en
);
  logic              tx_we, rx_we, core_we;
  logic [NUM_EP-1:0] tx_en_d, rx_en_d;
  logic [CORE_W-1:0] core_en_d;

  always_comb begin
    tx_we     = we && (en_sel_e'(addr) == SEL_TX_EN);
    rx_we     = we && (en_sel_e'(addr) == SEL_RX_EN);
    core_we   = we && (en_sel_e'(addr) == SEL_CORE_EN);
    tx_en_d   = wdata;
    rx_en_d   = wdata;
    core_en_d = wdata[CORE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= '1;
      rx_en   <= '1;
      core_en <= CORE_EN_RST;
    end else begin
      if (tx_we)   tx_en   <= tx_en_d;
      if (rx_we)   rx_en   <= rx_en_d;
      if (core_we) core_en <= core_en_d;
    end
  end

  // R9: enables only change on a write to a valid address
  a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || addr == 2'd3) |=> $stable({tx_en, rx_en, core_en}));
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0) |=> (tx_en == $past(wdata)));
endmodule

// File: rtl/usb_irq_aggregator.sv
`timescale 1ns/1ps
module usb_irq_aggregator #(
  parameter int                NUM_EP      = 16,
  parameter int                CORE_W      = 8,
  parameter logic [CORE_W-1:0] CORE_EN_RST = 8'h06,
  localparam int               IDX_W       = $clog2(NUM_EP),
  localparam int               RX_SHIFT    = NUM_EP - 1,
  localparam int               PK_W        = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_set_vld,
  input  logic              ep_set_dir,
  input  logic [IDX_W-1:0]  ep_set_idx,
  input  logic              ep_clr_vld,
  input  logic              ep_clr_dir,
  input  logic [IDX_W-1:0]  ep_clr_idx,
  input  logic [CORE_W-1:0] core_set,
  input  logic [CORE_W-1:0] core_clr,
  input  logic              bulk_clr_vld,
  input  logic [PK_W-1:0]   bulk_clr_mask,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [NUM_EP-1:0] reg_wdata,
  output logic [PK_W-1:0]   status_packed,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic [CORE_W-1:0] core_irq
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic [NUM_EP-1:0] tx_set, rx_set, tx_clr, rx_clr;
  logic [NUM_EP-1:0] tx_en, rx_en;
  logic [CORE_W-1:0] core_en;
  logic [NUM_EP-1:0] tx_keep, rx_keep;
  logic [NUM_EP-1:0] tx_stat, rx_stat;
  logic              core_any_unused;
  logic              unused_mask_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  ep_req_router #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_router (
    .set_vld(ep_set_vld), .set_dir(ep_set_dir), .set_idx(ep_set_idx),
    .clr_vld(ep_clr_vld), .clr_dir(ep_clr_dir), .clr_idx(ep_clr_idx),
    .tx_set(tx_set), .rx_set(rx_set), .tx_clr(tx_clr), .rx_clr(rx_clr)
  );

  irq_enable_regs #(.NUM_EP(NUM_EP), .CORE_W(CORE_W), .CORE_EN_RST(CORE_EN_RST)) u_en (
    .clk(clk), .rst_n(rst_s), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .tx_en(tx_en), .rx_en(rx_en), .core_en(core_en)
  );

  always_comb begin
    tx_keep = bulk_clr_vld ? bulk_clr_mask[NUM_EP-1:0]       : '1;
    rx_keep = bulk_clr_vld ? bulk_clr_mask[RX_SHIFT +: NUM_EP] : '1;
  end
  assign unused_mask_msb = bulk_clr_mask[PK_W-1];

  irq_bank #(.W(NUM_EP)) u_tx (
    .clk(clk), .rst_n(rst_s), .set_vec(tx_set), .clr_vec(tx_clr),
    .keep_vec(tx_keep), .en_vec(tx_en), .status(tx_stat), .any_irq(tx_irq)
  );

  irq_bank #(.W(NUM_EP)) u_rx (
    .clk(clk), .rst_n(rst_s), .set_vec(rx_set), .clr_vec(rx_clr),
    .keep_vec(rx_keep), .en_vec(rx_en), .status(rx_stat), .any_irq(rx_irq)
  );

  irq_bank #(.W(CORE_W)) u_core (
    .clk(clk), .rst_n(rst_s), .set_vec(core_set), .clr_vec(core_clr),
    .keep_vec({CORE_W{1'b1}}), .en_vec(core_en), .status(core_irq),
    .any_irq(core_any_unused)
  );

  assign status_packed = ({{NUM_EP{1'b0}}, rx_stat} << RX_SHIFT) | {{NUM_EP{1'b0}}, tx_stat};

  // R4: receive line 0 is never used
  a_r4_rx_line0_idle: assert property (@(posedge clk) disable iff (!rst_s)
    rx_stat[0] == 1'b0);
  // R6: bulk mask removes the bits it does not keep
  a_r6_bulk_tx: assert property (@(posedge clk) disable iff (!rst_s)
    bulk_clr_vld |=> ((tx_stat & ~$past(bulk_clr_mask[NUM_EP-1:0])) == '0));
  a_r6_bulk_rx: assert property (@(posedge clk) disable iff (!rst_s)
    bulk_clr_vld |=> ((rx_stat & ~$past(bulk_clr_mask[RX_SHIFT +: NUM_EP])) == '0));
endmodule

// File: tb/sim_usb_irq_aggregator.sv
`timescale 1ns/1ps
module sim_usb_irq_aggregator;
  localparam int VW = 79;
  localparam int NV = 14;
  // {set_vld,set_dir,set_idx, clr_vld,clr_dir,clr_idx, bulk_vld,bulk_mask, exp_packed, exp_tx, exp_rx}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {1'b1,1'b0,4'd3,  1'b0,1'b0,4'd0,  1'b0,32'h0,        32'h0000_0008, 1'b1,1'b0},
    {1'b1,1'b1,4'd2,  1'b0,1'b0,4'd0,  1'b0,32'h0,        32'h0002_0008, 1'b1,1'b1},
    {1'b1,1'b1,4'd0,  1'b0,1'b0,4'd0,  1'b0,32'h0,        32'h0002_0009, 1'b1,1'b1},
    {1'b0,1'b0,4'd0,  1'b1,1'b0,4'd3,  1'b0,32'h0,        32'h0002_0001, 1'b1,1'b1},
    {1'b0,1'b0,4'd0,  1'b1,1'b1,4'd0,  1'b0,32'h0,        32'h0002_0000, 1'b0,1'b1},
    {1'b1,1'b0,4'd15, 1'b0,1'b0,4'd0,  1'b0,32'h0,        32'h0002_8000, 1'b1,1'b1},
    {1'b1,1'b1,4'd15, 1'b0,1'b0,4'd0,  1'b0,32'h0,        32'h4002_8000, 1'b1,1'b1},
    {1'b1,1'b0,4'd5,  1'b1,1'b0,4'd5,  1'b0,32'h0,        32'h4002_8000, 1'b1,1'b1},
    {1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b1,32'h4000_0000,32'h4000_0000, 1'b0,1'b1},
    {1'b1,1'b0,4'd7,  1'b0,1'b0,4'd0,  1'b1,32'hFFFF_FFFF,32'h4000_0080, 1'b1,1'b1},
    {1'b1,1'b1,4'd9,  1'b0,1'b0,4'd0,  1'b0,32'h0,        32'h4100_0080, 1'b1,1'b1},
    {1'b0,1'b0,4'd0,  1'b1,1'b1,4'd15, 1'b0,32'h0,        32'h0100_0080, 1'b1,1'b1},
    {1'b0,1'b0,4'd0,  1'b1,1'b1,4'd9,  1'b0,32'h0,        32'h0000_0080, 1'b1,1'b0},
    {1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b1,32'h0000_FF7F,32'h0000_0000, 1'b0,1'b0}
  };

  logic        clk, rst_n;
  logic        ep_set_vld, ep_set_dir, ep_clr_vld, ep_clr_dir;
  logic [3:0]  ep_set_idx, ep_clr_idx;
  logic [7:0]  core_set, core_clr;
  logic        bulk_clr_vld;
  logic [31:0] bulk_clr_mask;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [31:0] status_packed;
  logic        tx_irq, rx_irq;
  logic [7:0]  core_irq;
  int          n_chk, n_bad;

  usb_irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n),
    .ep_set_vld(ep_set_vld), .ep_set_dir(ep_set_dir), .ep_set_idx(ep_set_idx),
    .ep_clr_vld(ep_clr_vld), .ep_clr_dir(ep_clr_dir), .ep_clr_idx(ep_clr_idx),
    .core_set(core_set), .core_clr(core_clr),
    .bulk_clr_vld(bulk_clr_vld), .bulk_clr_mask(bulk_clr_mask),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_packed(status_packed), .tx_irq(tx_irq), .rx_irq(rx_irq), .core_irq(core_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ep_set_vld = 0; ep_set_dir = 0; ep_set_idx = 0;
    ep_clr_vld = 0; ep_clr_dir = 0; ep_clr_idx = 0;
    core_set = 0; core_clr = 0; bulk_clr_vld = 0; bulk_clr_mask = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic ep_set(input logic dir, input logic [3:0] idx);
    ep_set_vld = 1; ep_set_dir = dir; ep_set_idx = idx;
  endtask

  task automatic ep_clr(input logic dir, input logic [3:0] idx);
    ep_clr_vld = 1; ep_clr_dir = dir; ep_clr_idx = idx;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset packed", status_packed, 32'h0);
    chk("R1 reset irqs", {22'h0, core_irq, tx_irq, rx_irq}, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {status_packed[23:0], core_irq}, 32'h0);

    // R2 R3 R4 R5 R6 R8 table
    for (int i = 0; i < NV; i++) begin
      ep_set_vld = VECS[i][78]; ep_set_dir = VECS[i][77]; ep_set_idx = VECS[i][76:73];
      ep_clr_vld = VECS[i][72]; ep_clr_dir = VECS[i][71]; ep_clr_idx = VECS[i][70:67];
      bulk_clr_vld = VECS[i][66]; bulk_clr_mask = VECS[i][65:34];
      cyc();
      chk($sformatf("R5 vec %0d packed", i), status_packed, VECS[i][33:2]);
      chk($sformatf("R3 vec %0d shared irqs", i), {30'h0, tx_irq, rx_irq}, {30'h0, VECS[i][1:0]});
    end

    // R1 R7: default core enable lets only lines 1 and 2 through
    core_set = 8'hFF; cyc();
    chk("R7 core default enable", {24'h0, core_irq}, 32'h06);
    core_clr = 8'h02; cyc();
    chk("R7 core clear", {24'h0, core_irq}, 32'h04);
    // R9 core enable write
    wr(2'd2, 16'h0081); cyc();
    core_set = 8'hFF; cyc();
    chk("R9 core enable write", {24'h0, core_irq}, 32'h85);
    // R8 core set and clear together
    core_set = 8'h80; core_clr = 8'h80; cyc();
    chk("R8 core clear wins", {24'h0, core_irq}, 32'h05);

    // R2 disabled request dropped, not pending
    wr(2'd0, 16'hFFEF); cyc();
    ep_set(1'b0, 4'd4); cyc();
    chk("R2 disabled set dropped", status_packed, 32'h0);
    chk("R2 tx irq stays low", {31'h0, tx_irq}, 32'h0);
    wr(2'd0, 16'hFFFF); cyc();
    cyc();
    chk("R2 not held pending", status_packed, 32'h0);

    // R9 old enable applies in the write cycle
    wr(2'd1, 16'h0000); ep_set(1'b1, 4'd6); cyc();
    chk("R9 old enable in write cycle", status_packed, 32'h0020_0000);
    chk("R9 rx irq", {31'h0, rx_irq}, 32'h1);
    ep_set(1'b1, 4'd7); cyc();
    chk("R9 new rx enable blocks", status_packed, 32'h0020_0000);
    wr(2'd3, 16'h0000); cyc();
    ep_set(1'b0, 4'd2); cyc();
    chk("R9 address 3 no effect", status_packed, 32'h0020_0004);

    // R4 receive line 0 lands in transmit bit 0 with transmit enable
    ep_set(1'b1, 4'd0); cyc();
    chk("R4 rx line0 redirect", status_packed, 32'h0020_0005);
    ep_clr(1'b0, 4'd2); cyc();
    chk("R3 partial clear", status_packed, 32'h0020_0001);
    chk("R3 tx irq held", {31'h0, tx_irq}, 32'h1);

    // R6 R8 bulk clear wins over a set
    ep_set(1'b0, 4'd3); bulk_clr_vld = 1; bulk_clr_mask = 32'hFFFF_FFF6; cyc();
    chk("R6 bulk over set", status_packed, 32'h0020_0000);
    chk("R6 irqs after bulk", {30'h0, tx_irq, rx_irq}, 32'h1);

    // R1 asynchronous reset mid-run
    rst_n = 0;
    #3;
    chk("R1 async reset outputs", {status_packed[23:0], core_irq}, 32'h0);
    chk("R1 async reset irqs", {30'h0, tx_irq, rx_irq}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    core_set = 8'hFF; cyc();
    chk("R1 core enable back to 06", {24'h0, core_irq}, 32'h06);
    ep_set(1'b1, 4'd6); cyc();
    chk("R1 rx enable back to ones", status_packed, 32'h0020_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule